// File: doc/BRIEF.md
# Serial Converter Digital-Side Emulator

This block stands in for the digital side of a 16-bit successive-approximation converter wired in three-wire mode with a busy indicator. It lets a host controller's serial-read logic be exercised in loopback. No analog front end is needed. The host drives a convert line and a serial clock. The emulator answers on a data line, with a separate output-enable that stands for a tri-stated driver: when the enable is low, the line counts as high impedance.

A rising edge on the convert line starts a conversion. The sample word from a test register is captured at that moment. The driver is released for a fixed number of system clocks, whatever the convert line does in that time. If the convert line is low when the time runs out, the driver turns on and pulls the line low as a completion interrupt. Each later falling serial-clock edge then presents the next bit, most significant first. The driver lets go on the edge after the last bit, or at once when the convert line rises again, whichever comes first. If the convert line is still high when the conversion ends, no busy indication is given and a sticky flag records the miss.

The convert and serial-clock inputs are treated as asynchronous. They pass through a synchronizer of configurable depth, and all edges are detected in the system clock domain.

Top module: `adc_emu_top`

## Requirements
- R1: After reset the output-enable is 0, the data output is 0 and the missed-busy flag is 0.
- R2: A rising convert edge while no conversion is running starts a conversion. The output-enable stays 0 for the full conversion time, and convert edges during that time neither restart nor shorten it.
- R3: When the conversion time ends with the convert line low, the output-enable becomes 1 and the data output is 0 (busy level) until the first serial-clock falling edge.
- R4: Once the output is enabled, the n-th serial-clock falling edge (n = 1..16) drives bit 16-n of the captured word, so bit 15 comes first and bit 0 comes last.
- R5: The 17th falling edge after completion sets the output-enable to 0.
- R6: A rising convert edge while the output is enabled sets the output-enable to 0 at once and starts a new conversion, which captures a new sample and restarts the bit order at bit 15.
- R7: The sample word is captured on the convert rising edge. Changes to the sample input after that do not affect the bits shifted out.
- R8: If the convert line is high when the conversion time ends, the output-enable stays 0 and the missed-busy flag becomes 1. The flag clears when the next conversion starts.
- R9: Serial-clock falling edges during a conversion or while the output is released do not change the output-enable, and they do not advance the bit order.
- R10: Serial-clock rising edges never change the data output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cnvIn | input | 1 | Convert line from host (asynchronous) |
| sckIn | input | 1 | Serial clock from host (asynchronous) |
| sampleIn | input | DATA_W | Test-register sample word |
| sdoOut | output | 1 | Serial data value |
| sdoOe | output | 1 | Data driver enable; 0 models high impedance |
| busyMissed | output | 1 | Sticky flag: conversion ended with convert high |

## Verification
The bench builds the block with a 16-bit word, a conversion time of 12 system clocks and a two-stage synchronizer. The short conversion window lets the bench do two things in one run. It can toggle the convert line and pulse the serial clock while a conversion is running, and it can still place the convert line either low or high at the moment the conversion ends. That covers both the normal busy-low path and the missed-busy path. With the full 16-bit width, the bench also reaches the 17th-edge release, the extra edges after it, and an early release by a convert edge in the middle of a frame.

// File: rtl/adc_emu_pkg.sv
package adc_emu_pkg;

  typedef enum logic [1:0] {
    ST_ACQ  = 2'd0,
    ST_CONV = 2'd1,
    ST_DATA = 2'd2
  } emuState_t;

  typedef struct packed {
    logic load;
    logic shift;
  } dpStrobe_t;

endpackage

// File: rtl/adc_emu_sync.sv
module adc_emu_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic lvl,
  output logic lvlPrev
);

  logic [STAGES-1:0] chainQ;
  logic              prevQ;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chainQ <= '0;
        else       chainQ <= asyncIn;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chainQ <= '0;
        else       chainQ <= {chainQ[STAGES-2:0], asyncIn};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= chainQ[STAGES-1];
  end

  assign lvl     = chainQ[STAGES-1];
  assign lvlPrev = prevQ;

endmodule

// File: rtl/adc_emu_ctrl.sv
module adc_emu_ctrl
  import adc_emu_pkg::*;
#(
  parameter int CONV_CYCLES = 50,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      cnvIn,
  input  logic      sckIn,
  input  logic      frameEnd,
  output dpStrobe_t strobe,
  output logic      oe,
  output logic      missed
);

  localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CONV_CYCLES - 1);

  logic cnvLvl, cnvPrev, sckLvl, sckPrev;
  logic cnvRise, sckFall;

  adc_emu_sync #(.STAGES(SYNC_STAGES)) u_cnvSync (
    .clk(clk), .rstN(rstN), .asyncIn(cnvIn), .lvl(cnvLvl), .lvlPrev(cnvPrev)
  );
  adc_emu_sync #(.STAGES(SYNC_STAGES)) u_sckSync (
    .clk(clk), .rstN(rstN), .asyncIn(sckIn), .lvl(sckLvl), .lvlPrev(sckPrev)
  );

  assign cnvRise = cnvLvl & ~cnvPrev;
  assign sckFall = sckPrev & ~sckLvl;

  emuState_t        stateQ, stateD;
  logic [CNT_W-1:0] convCntQ, convCntD;
  logic             missedQ, missedD;

  always_comb begin
    stateD       = stateQ;
    convCntD     = convCntQ;
    missedD      = missedQ;
    strobe.load  = 1'b0;
    strobe.shift = 1'b0;
    unique case (stateQ)
      ST_ACQ: begin
        if (cnvRise) begin
          stateD      = ST_CONV;
          convCntD    = CNT_LOAD;
          missedD     = 1'b0;
          strobe.load = 1'b1;
        end
      end
      ST_CONV: begin
        if (convCntQ != '0) begin
          convCntD = convCntQ - 1'b1;
        end else if (cnvLvl) begin
          stateD  = ST_ACQ;
          missedD = 1'b1;
        end else begin
          stateD = ST_DATA;
        end
      end
      ST_DATA: begin
        if (cnvRise) begin
          stateD      = ST_CONV;
          convCntD    = CNT_LOAD;
          missedD     = 1'b0;
          strobe.load = 1'b1;
        end else if (sckFall) begin
          if (frameEnd) stateD = ST_ACQ;
          else          strobe.shift = 1'b1;
        end
      end
      default: stateD = ST_ACQ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_ACQ;
      convCntQ <= '0;
      missedQ  <= 1'b0;
    end else begin
      stateQ   <= stateD;
      convCntQ <= convCntD;
      missedQ  <= missedD;
    end
  end

  assign oe     = (stateQ == ST_DATA);
  assign missed = missedQ;

  // R2: a convert edge from acquisition begins a full-length conversion
  p_conv_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_ACQ && cnvRise) |=> (stateQ == ST_CONV && convCntQ == CNT_LOAD));

  // R2: conversion cannot end early while the counter is nonzero
  p_conv_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_CONV && convCntQ != '0) |=> (stateQ == ST_CONV && !oe));

  // R3: completion with convert low enables the driver
  p_busy_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_CONV && convCntQ == '0 && !cnvLvl) |=> oe);

  // R8: completion with convert high records the miss and keeps the driver off
  p_missed_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_CONV && convCntQ == '0 && cnvLvl) |=> (missed && !oe));

  // R6: a convert edge during readout turns the driver off next cycle
  p_early_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    (oe && cnvRise) |=> !oe);

endmodule

// File: rtl/adc_emu_dp.sv
module adc_emu_dp
  import adc_emu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] sampleIn,
  input  dpStrobe_t         strobe,
  output logic              sdoBit,
  output logic              frameEnd
);

  localparam int BC_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] shiftQ;
  logic [BC_W-1:0]   bitCntQ;
  logic              outBitQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ  <= '0;
      bitCntQ <= '0;
      outBitQ <= 1'b0;
    end else if (strobe.load) begin
      shiftQ  <= sampleIn;
      bitCntQ <= '0;
      outBitQ <= 1'b0;
    end else if (strobe.shift) begin
      outBitQ <= shiftQ[DATA_W-1];
      shiftQ  <= {shiftQ[DATA_W-2:0], 1'b0};
      bitCntQ <= bitCntQ + 1'b1;
    end
  end

  assign sdoBit   = outBitQ;
  assign frameEnd = (bitCntQ == BC_W'(DATA_W));

  // R3: a new conversion leaves the line at busy level with the count cleared
  p_load_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (!sdoBit && !frameEnd));

  // R4: every shift advances the bit position by exactly one
  p_shift_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shift |=> (bitCntQ == $past(bitCntQ) + 1'b1));

  // R10: without a strobe the output bit and count hold
  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.shift) |=> ($stable(sdoBit) && $stable(bitCntQ)));

endmodule

// File: rtl/adc_emu_top.sv
module adc_emu_top
  import adc_emu_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 50,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cnvIn,
  input  logic              sckIn,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              sdoOut,
  output logic              sdoOe,
  output logic              busyMissed
);

  dpStrobe_t strobe;
  logic      frameEnd;

  adc_emu_ctrl #(
    .CONV_CYCLES(CONV_CYCLES),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cnvIn(cnvIn), .sckIn(sckIn),
    .frameEnd(frameEnd), .strobe(strobe), .oe(sdoOe), .missed(busyMissed)
  );

  adc_emu_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .strobe(strobe),
    .sdoBit(sdoOut), .frameEnd(frameEnd)
  );

endmodule

// File: tb/adc_emu_top_tb_top.sv
module adc_emu_top_tb_top;

  localparam int DW   = 16;
  localparam int CONV = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cnvIn = 1'b0;
  logic          sckIn = 1'b0;
  logic [DW-1:0] sampleIn = '0;
  logic          sdoOut, sdoOe, busyMissed;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  adc_emu_top #(.DATA_W(DW), .CONV_CYCLES(CONV), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rstN(rstN), .cnvIn(cnvIn), .sckIn(sckIn), .sampleIn(sampleIn),
    .sdoOut(sdoOut), .sdoOe(sdoOe), .busyMissed(busyMissed)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sckPulse();
    sckIn = 1'b1;
    waitClk(4);
    sckIn = 1'b0;
    waitClk(4);
  endtask

  task automatic readFrame(input logic [DW-1:0] word, input string req);
    for (int n = 1; n <= DW; n++) begin
      sckPulse();
      chk(sdoOut == word[DW-n] && sdoOe, req, int'(sdoOut), int'(word[DW-n]));
    end
  endtask

  task automatic testReset();
    waitClk(1);
    chk(sdoOe == 0, "R1", sdoOe, 0);
    chk(sdoOut == 0, "R1", sdoOut, 0);
    chk(busyMissed == 0, "R1", busyMissed, 0);
  endtask

  task automatic testNormalFrame();
    logic [DW-1:0] word = 16'hA5C3;
    sampleIn = word;
    cnvIn = 1'b1;
    waitClk(4);
    sampleIn = 16'h0F0F;               // R7: later change must not matter
    chk(sdoOe == 0, "R2", sdoOe, 0);
    cnvIn = 1'b0;
    waitClk(2);
    cnvIn = 1'b1;                      // R2: toggle during conversion
    waitClk(2);
    cnvIn = 1'b0;
    waitClk(CONV + 1 - 8);
    chk(sdoOe == 0, "R2", sdoOe, 0);
    waitClk(3);
    chk(sdoOe == 1, "R3", sdoOe, 1);
    chk(sdoOut == 0, "R3", sdoOut, 0);
    sckIn = 1'b1;                      // R10: rising edge alone
    waitClk(4);
    chk(sdoOut == 0, "R10", sdoOut, 0);
    sckIn = 1'b0;
    waitClk(4);
    chk(sdoOut == word[DW-1], "R4", sdoOut, word[DW-1]);
    for (int n = 2; n <= DW; n++) begin
      sckPulse();
      chk(sdoOut == word[DW-n], "R7", sdoOut, word[DW-n]);
    end
    chk(sdoOe == 1, "R4", sdoOe, 1);
    sckPulse();
    chk(sdoOe == 0, "R5", sdoOe, 0);
    sckPulse();
    sckPulse();
    chk(sdoOe == 0, "R9", sdoOe, 0);
  endtask

  task automatic testMissedAndEarly();
    logic [DW-1:0] w1 = 16'h3E71;
    logic [DW-1:0] w2 = 16'hC018;
    sampleIn = 16'h1234;
    cnvIn = 1'b1;
    waitClk(CONV + 6);
    chk(sdoOe == 0, "R8", sdoOe, 0);
    chk(busyMissed == 1, "R8", busyMissed, 1);
    cnvIn = 1'b0;
    waitClk(4);
    sampleIn = w1;
    cnvIn = 1'b1;
    waitClk(2);
    cnvIn = 1'b0;
    waitClk(3);
    chk(busyMissed == 0, "R8", busyMissed, 0);
    waitClk(CONV + 2);
    chk(sdoOe == 1, "R3", sdoOe, 1);
    for (int n = 1; n <= 5; n++) begin
      sckPulse();
      chk(sdoOut == w1[DW-n], "R4", sdoOut, w1[DW-n]);
    end
    sampleIn = w2;
    cnvIn = 1'b1;
    waitClk(2);
    cnvIn = 1'b0;
    sckPulse();                        // R9: falling edge during conversion
    chk(sdoOe == 0, "R6", sdoOe, 0);
    waitClk(6);
    chk(sdoOe == 1, "R6", sdoOe, 1);
    chk(sdoOut == 0, "R6", sdoOut, 0);
    readFrame(w2, "R9");
    sckPulse();
    chk(sdoOe == 0, "R5", sdoOe, 0);
  endtask

  initial begin
    waitClk(3);
    rstN = 1'b1;
    testReset();
    testNormalFrame();
    testMissedAndEarly();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule